// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Controller

This block keeps the eight-bit status byte of a serial NOR flash and decides which instructions may change it. A front end that has already shifted in and decoded each instruction presents one strobe per instruction: write enable, write disable, status write with its data byte, page program, sector erase and chip erase. The block returns the status byte for read-back. It also returns a protected-range indication: an enable, plus the lowest protected byte address. The array controller compares this address against the target of a program or erase.

The two protection fields, a three-bit range code and a lock bit, stand for non-volatile cells. They are ordinary flops that the power-up reset leaves alone, so they survive a reset. A status write takes a fixed number of cycles, and its new value appears only when the busy period ends. A program or erase stays busy until the array controller returns a completion pulse. The lock bit and the active-low write-protect pin together decide whether a status write is refused.

Top module: `nor_status_reg`

## Requirements
- R1: The status byte reads bit 0 = busy, bit 1 = write-enable latch, bits 4:2 = range code, bit 7 = lock bit. Bits 6:5 always read 0, whatever data was written.
- R2: The power-up reset (rst_n low) clears busy and the write-enable latch, even in the middle of a status write. The range code and lock bit keep their values, and an interrupted status write commits nothing.
- R3: A write-enable strobe sets the latch and a write-disable strobe clears it, one cycle later. Both are ignored while busy reads 1, so the latch is never 1 while busy is 1.
- R4: A status write, page program, sector erase or chip erase is ignored while the latch reads 0 or busy reads 1. An ignored strobe leaves the whole status byte unchanged.
- R5: An accepted status write clears the latch and sets busy on the next cycle. Busy then stays 1 for exactly WRSR_CYCLES cycles. On the cycle busy falls, bits 7 and 4:2 take data bits 7 and 4:2. Data bits 6:5 and 1:0 are never stored.
- R6: An accepted program or erase clears the latch and sets busy, and busy holds until an op_done_i pulse. A pulse of op_done_i while idle, or during a status write, has no effect.
- R7: With the lock bit at 0, wp_n_i has no effect on status writes. With the lock bit at 1, a status write is ignored while wp_n_i is low (the latch stays 1) and accepted while wp_n_i is high.
- R8: For range code c, prot_en_o is 1 exactly when c is not 0. For c in 1..6, prot_base_o equals 2^ADDR_W minus 2^(ADDR_W-7+c), so the top 1/64, 1/32, ..., 1/2 of the array is protected. For c = 0 and c = 7, prot_base_o is 0.
- R9: An instruction strobed in the last cycle of a busy period is judged against busy = 1 and ignored. This covers both the cycle of the op_done_i pulse and the final cycle of a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| wren_i | input | 1 | Write-enable instruction strobe |
| wrdi_i | input | 1 | Write-disable instruction strobe |
| wrsr_i | input | 1 | Status-write instruction strobe |
| wrsr_data_i | input | 8 | Data byte for the status write |
| pp_i | input | 1 | Page-program instruction strobe |
| se_i | input | 1 | Sector-erase instruction strobe |
| ce_i | input | 1 | Chip-erase instruction strobe |
| op_done_i | input | 1 | Completion pulse of a program or erase |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte for read-back |
| prot_en_o | output | 1 | Some part of the array is protected |
| prot_base_o | output | ADDR_W | Lowest protected byte address |

## Verification
A new instruction can arrive in the same cycle that a busy period ends. One case is a write-enable strobe raised together with the op_done_i pulse that finishes a program. The other is a write-enable strobe raised in the final counted cycle of a status write, so the commit and the strobe share one clock edge. In both cases the bench expects busy to read 0 and the latch to read 0 on the next cycle. For the status write it also expects the new protection bits to be present, so the strobe must have been ignored without disturbing the commit. An exhaustive sweep of every data byte under both pin levels checks the lock rule against a model of the lock bit and range code kept in the bench.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  // Bit positions inside the status byte; the read-back layout depends on them.
  localparam int SR_BUSY   = 0;
  localparam int SR_WEL    = 1;
  localparam int SR_CODE_L = 2;
  localparam int SR_CODE_H = 4;
  localparam int SR_LOCK   = 7;

  // Cause of the current busy period.
  typedef enum logic [1:0] {
    BSY_IDLE   = 2'd0,
    BSY_STATUS = 2'd1,
    BSY_ARRAY  = 2'd2
  } busy_kind_e;

  // Non-volatile part of the status byte.
  typedef struct packed {
    logic       lock;
    logic [2:0] code;
  } nv_bits_t;

endpackage

// File: rtl/nsr_wel.sv
module nsr_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  logic wel_q;
  logic wel_d;

  always_comb begin
    wel_d = wel_q;
    if (clr_i)      wel_d = 1'b0;
    else if (set_i) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  assign wel_o = wel_q;

endmodule

// File: rtl/nsr_busy_seq.sv
module nsr_busy_seq
  import nsr_pkg::*;
#(
  parameter int WRSR_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_status_i,
  input  logic     start_array_i,
  input  nv_bits_t nv_new_i,
  input  logic     op_done_i,
  output logic     busy_o,
  output logic     commit_o,
  output nv_bits_t nv_pend_o
);

  localparam int         CNT_W = (WRSR_CYCLES > 1) ? $clog2(WRSR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRSR_CYCLES - 1);

  busy_kind_e       kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  nv_bits_t         pend_q;
  logic             pend_en;

  always_comb begin
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    pend_en = 1'b0;
    case (kind_q)
      BSY_IDLE: begin
        if (start_status_i) begin
          kind_d  = BSY_STATUS;
          cnt_d   = CNT_LOAD;
          pend_en = 1'b1;
        end else if (start_array_i) begin
          kind_d  = BSY_ARRAY;
        end
      end
      BSY_STATUS: begin
        if (cnt_q == '0) kind_d = BSY_IDLE;
        else             cnt_d  = cnt_q - 1'b1;
      end
      BSY_ARRAY: begin
        if (op_done_i) kind_d = BSY_IDLE;
      end
      default: kind_d = BSY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= BSY_IDLE;
      cnt_q  <= '0;
    end else begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
    end
  end

  // Pending data is only meaningful while a status write is counting.
  always_ff @(posedge clk) begin
    if (pend_en) pend_q <= nv_new_i;
  end

  assign busy_o    = (kind_q != BSY_IDLE);
  assign commit_o  = (kind_q == BSY_STATUS) && (cnt_q == '0);
  assign nv_pend_o = pend_q;

endmodule

// File: rtl/nsr_nv_bits.sv
module nsr_nv_bits
  import nsr_pkg::*;
(
  input  logic     clk,
  input  logic     commit_i,
  input  nv_bits_t pend_i,
  output nv_bits_t nv_o
);

  nv_bits_t nv_q;
  nv_bits_t nv_d;

  always_comb begin
    nv_d = nv_q;
    if (commit_i) nv_d = pend_i;
  end

  // Models non-volatile cells: deliberately outside the power-up reset.
  always_ff @(posedge clk) begin
    nv_q <= nv_d;
  end

  assign nv_o = nv_q;

endmodule

// File: rtl/nsr_prot_map.sv
module nsr_prot_map #(
  parameter int ADDR_W = 19
) (
  input  logic [2:0]        code_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] base_o
);

  localparam int LOW_BIT = ADDR_W - 6;

  logic partial;

  assign en_o    = (code_i != 3'd0);
  assign partial = (code_i != 3'd0) && (code_i != 3'd7);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i >= LOW_BIT) begin : g_cmp
      localparam int LIM = i - ADDR_W + 7;
      assign base_o[i] = partial && (code_i <= 3'(LIM));
    end else begin : g_zero
      assign base_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/nor_status_reg.sv
module nor_status_reg
  import nsr_pkg::*;
#(
  parameter int WRSR_CYCLES = 8,
  parameter int ADDR_W      = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              pp_i,
  input  logic              se_i,
  input  logic              ce_i,
  input  logic              op_done_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              prot_en_o,
  output logic [ADDR_W-1:0] prot_base_o
);

  logic     wel;
  logic     busy;
  logic     commit;
  logic     may_write;
  logic     sr_locked;
  logic     acc_status;
  logic     acc_array;
  logic     wel_set;
  logic     wel_clr;
  nv_bits_t nv_cur;
  nv_bits_t nv_new;
  nv_bits_t nv_pend;

  // Admission of instructions; a status write takes priority over an array op.
  always_comb begin
    may_write  = wel && !busy;
    sr_locked  = nv_cur.lock && !wp_n_i;
    acc_status = wrsr_i && may_write && !sr_locked;
    acc_array  = (pp_i || se_i || ce_i) && may_write && !wrsr_i;
    wel_set    = wren_i && !busy;
    wel_clr    = (wrdi_i && !busy) || acc_status || acc_array;
    nv_new     = '{lock: wrsr_data_i[SR_LOCK], code: wrsr_data_i[SR_CODE_H:SR_CODE_L]};
  end

  nsr_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wel_set),
    .clr_i (wel_clr),
    .wel_o (wel)
  );

  nsr_busy_seq #(
    .WRSR_CYCLES (WRSR_CYCLES)
  ) u_busy (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_status_i (acc_status),
    .start_array_i  (acc_array),
    .nv_new_i       (nv_new),
    .op_done_i      (op_done_i),
    .busy_o         (busy),
    .commit_o       (commit),
    .nv_pend_o      (nv_pend)
  );

  nsr_nv_bits u_nv (
    .clk      (clk),
    .commit_i (commit),
    .pend_i   (nv_pend),
    .nv_o     (nv_cur)
  );

  nsr_prot_map #(
    .ADDR_W (ADDR_W)
  ) u_map (
    .code_i (nv_cur.code),
    .en_o   (prot_en_o),
    .base_o (prot_base_o)
  );

  assign status_o = {nv_cur.lock, 2'b00, nv_cur.code, wel, busy};

endmodule

// File: rtl/nsr_status_sva.sv
module nsr_status_sva #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wren_i,
  input logic              wrdi_i,
  input logic              wrsr_i,
  input logic              pp_i,
  input logic              se_i,
  input logic              ce_i,
  input logic              wp_n_i,
  input logic [7:0]        status_o,
  input logic              prot_en_o,
  input logic [ADDR_W-1:0] prot_base_o
);

  logic any_arr;
  assign any_arr = pp_i || se_i || ce_i;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00);

  a_r3_busy_no_wel: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> !status_o[1]);

  a_r4_no_start_without_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[1] && !status_o[0]) |=> !status_o[0]);

  a_r5_status_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && status_o[1] && !status_o[0] && !(status_o[7] && !wp_n_i))
      |=> (status_o[0] && !status_o[1]));

  a_r6_array_start: assert property (@(posedge clk) disable iff (!rst_n)
    (any_arr && !wrsr_i && status_o[1] && !status_o[0])
      |=> (status_o[0] && !status_o[1]));

  a_r7_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && status_o[7] && !wp_n_i && !status_o[0] && !wren_i && !wrdi_i && !any_arr)
      |=> $stable(status_o));

  a_r8_en_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en_o == (status_o[4:2] != 3'd0));

  a_r8_full_base: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4:2] == 3'd7 || status_o[4:2] == 3'd0) |-> (prot_base_o == '0));

  a_r9_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && wren_i) |=> !status_o[1]);

endmodule

bind nor_status_reg nsr_status_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .wren_i      (wren_i),
  .wrdi_i      (wrdi_i),
  .wrsr_i      (wrsr_i),
  .pp_i        (pp_i),
  .se_i        (se_i),
  .ce_i        (ce_i),
  .wp_n_i      (wp_n_i),
  .status_o    (status_o),
  .prot_en_o   (prot_en_o),
  .prot_base_o (prot_base_o)
);

// File: tb/nor_status_reg_test.sv
`timescale 1ns/1ps
module nor_status_reg_test;

  localparam int W  = 5;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wren_i, wrdi_i, wrsr_i, pp_i, se_i, ce_i, op_done_i, wp_n_i;
  logic [7:0]    wrsr_data_i;
  logic [7:0]    status_o;
  logic          prot_en_o;
  logic [AW-1:0] prot_base_o;

  int vectors = 0;
  int fails   = 0;

  logic       e_lock;
  logic [2:0] e_code;

  always #2.5 clk = ~clk;

  nor_status_reg #(.WRSR_CYCLES(W), .ADDR_W(AW)) uut (
    .clk, .rst_n, .wren_i, .wrdi_i, .wrsr_i, .wrsr_data_i, .pp_i, .se_i, .ce_i,
    .op_done_i, .wp_n_i, .status_o, .prot_en_o, .prot_base_o
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sb(input logic wel, input logic busy);
    return {e_lock, 2'b00, e_code, wel, busy};
  endfunction

  function automatic int exp_base(input logic [2:0] c);
    if (c == 3'd0 || c == 3'd7) return 0;
    return (1 << AW) - (1 << (AW - 7 + int'(c)));
  endfunction

  // kind: 0 wren, 1 wrdi, 2 status write, 3 program, 4 sector erase, 5 chip erase, 6 done
  task automatic issue(input int kind, input logic [7:0] d);
    @(negedge clk);
    wrsr_data_i = d;
    case (kind)
      0: wren_i = 1'b1;
      1: wrdi_i = 1'b1;
      2: wrsr_i = 1'b1;
      3: pp_i = 1'b1;
      4: se_i = 1'b1;
      5: ce_i = 1'b1;
      default: op_done_i = 1'b1;
    endcase
    @(negedge clk);
    {wren_i, wrdi_i, wrsr_i, pp_i, se_i, ce_i, op_done_i} = '0;
  endtask

  task automatic full_write(input logic [7:0] d, input logic wp);
    logic acc;
    wp_n_i = wp;
    issue(0, 8'h00);
    chk("R3 wel set", status_o, sb(1'b1, 1'b0));
    acc = !(e_lock && !wp);
    issue(2, d);
    if (acc) begin
      chk("R5 start", status_o, sb(1'b0, 1'b1));
      repeat (W - 1) @(negedge clk);
      chk("R5 busy last", status_o[0], 1);
      @(negedge clk);
      e_lock = d[7];
      e_code = d[4:2];
      chk("R5 R1 commit", status_o, sb(1'b0, 1'b0));
      chk("R8 en", prot_en_o, (e_code != 3'd0));
      chk("R8 base", prot_base_o, exp_base(e_code));
    end else begin
      chk("R7 locked", status_o, sb(1'b1, 1'b0));
      issue(1, 8'h00);
      chk("R3 wel clr", status_o, sb(1'b0, 1'b0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {wren_i, wrdi_i, wrsr_i, pp_i, se_i, ce_i, op_done_i} = '0;
    wrsr_data_i = 8'h00;
    wp_n_i = 1'b1;
    e_lock = 1'b0;
    e_code = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset volatile", status_o[1:0], 0);
    chk("R1 reset reserved", status_o[6:5], 0);
    full_write(8'h00, 1'b1);

    // Exhaustive sweep: every data byte under both pin levels (R1 R5 R7 R8)
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 2; p++) full_write(8'(d), p[0]);
    end

    // R8: every code once more with the pin high
    for (int c = 0; c < 8; c++) full_write({1'b0, 2'b11, 3'(c), 2'b11}, 1'b1);

    // R4: no latch, nothing accepted
    issue(2, 8'h9C);
    chk("R4 status write no wel", status_o, sb(1'b0, 1'b0));
    issue(3, 8'h00);
    chk("R4 program no wel", status_o, sb(1'b0, 1'b0));

    // R6 / R3 / R4: array ops hold busy until done
    for (int k = 3; k < 6; k++) begin
      issue(0, 8'h00);
      issue(k, 8'h00);
      chk("R6 array start", status_o, sb(1'b0, 1'b1));
      repeat (W + 3) @(negedge clk);
      chk("R6 still busy", status_o, sb(1'b0, 1'b1));
      issue(0, 8'h00);
      chk("R3 wren ignored busy", status_o, sb(1'b0, 1'b1));
      issue(2, 8'hFC);
      chk("R4 ignored busy", status_o, sb(1'b0, 1'b1));
      issue(6, 8'h00);
      chk("R6 done", status_o, sb(1'b0, 1'b0));
      issue(6, 8'h00);
      chk("R6 stray done", status_o, sb(1'b0, 1'b0));
    end

    // R9: wren together with the done pulse
    issue(0, 8'h00);
    issue(3, 8'h00);
    @(negedge clk);
    op_done_i = 1'b1;
    wren_i = 1'b1;
    @(negedge clk);
    {wren_i, op_done_i} = '0;
    chk("R9 done collision", status_o, sb(1'b0, 1'b0));
    issue(0, 8'h00);
    chk("R9 wren after", status_o, sb(1'b1, 1'b0));
    issue(1, 8'h00);

    // R9 / R6: wren in the final status-write cycle, done pulse mid-way
    wp_n_i = 1'b1;
    issue(0, 8'h00);
    issue(2, 8'h94);
    @(negedge clk);
    op_done_i = 1'b1;
    @(negedge clk);
    op_done_i = 1'b0;
    repeat (W - 3) @(negedge clk);
    chk("R6 done ignored in status write", status_o[0], 1);
    wren_i = 1'b1;
    @(negedge clk);
    wren_i = 1'b0;
    e_lock = 1'b1;
    e_code = 3'd5;
    chk("R9 commit collision", status_o, sb(1'b0, 1'b0));

    // R2: reset during a status write keeps the old protection bits
    issue(0, 8'h00);
    issue(2, 8'h08);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 in reset", status_o, sb(1'b0, 1'b0));
    rst_n = 1'b1;
    repeat (W + 2) @(negedge clk);
    chk("R2 no commit", status_o, sb(1'b0, 1'b0));
    chk("R2 base kept", prot_base_o, exp_base(e_code));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule